// File: doc/BRIEF.md
# Tri-Mode Buck Pulse Controller

This block is the digital back end of a buck converter controller. It divides the clock into switching cycles of fixed length. In each cycle it decides whether a pulse is issued, and it produces the high-side and low-side gate enables for that cycle. Three operating modes are available. Fixed-frequency PWM issues a pulse in every cycle. Dithered skip mode drops pulses in a rotating pattern. Pulse-frequency mode issues a pulse only when the regulation comparator reports that the output is below target.

The mode comes from a thermometer load word that a load-sensing converter delivers. The word is sampled only once every several switching cycles, and the block drives a sampling strobe for this purpose. Three bits of the word are tapped to form a two-bit mode code. The number of ones in the word sets how many skip groups follow the normal cycles in each skip period, so a lighter load gives a longer period. In pulse-frequency mode the regulation and current-limit comparators gate the pulses. In the other modes both comparators are treated as forced to 1. A zero-current comparator cuts the low-side switch for the rest of the cycle.

Top module: `buck_mode_pulser`

## Requirements
- R1: At each sample the mode code is {loadWord[TAP_HI], NOT(loadWord[TAP_MID] OR loadWord[TAP_LO])}, with bit 1 the PWM request and bit 0 the PFM request. Code 10 selects PWM, 00 selects dithered skip, 01 selects PFM, and 11 falls back to PWM. Defaults are taps 6, 3 and 1 of an 8-bit word.
- R2: sampleClk is high only during the last clock of every SAMPLE_CYCLES-th switching cycle. The load word is captured only in that clock. The new mode and skip count apply from the next switching cycle on. A load change at any other time has no effect.
- R3: In a cycle with a pulse, hsEn is high for switching-cycle phases 0 to D-1. D is the duty input as latched at the end of the previous cycle, clamped to CYCLE_LEN-2. Duty 0 gives no high-side pulse.
- R4: In a cycle with a pulse and D>0, lsEn is high for phases D+1 to CYCLE_LEN-2. lsEn is low in cycles without a pulse. hsEn and lsEn are never high together, and at least one clock separates them at each handover.
- R5: In dithered skip mode, each skip group of three consecutive cycles omits exactly one pulse.
- R6: A skip period is NORM_CYCLES pulsed cycles followed by M skip groups. M = LOAD_BITS minus the count of ones in the sampled word, clamped to [1, MAX_MODS].
- R7: The skipped slot of skip group j is slot (j mod 3), where j counts groups since entering skip mode. Entering skip mode from another mode restarts the sequence with a normal cycle.
- R8: In PFM mode a cycle carries a pulse exactly when regBelow was high in the last clock of the previous cycle.
- R9: In PFM mode, limitOk low blocks hsEn at once and keeps it low for the rest of that cycle.
- R10: Outside PFM mode, regBelow and limitOk have no effect: every PWM cycle is pulsed, and the high-side pulse runs its full width.
- R11: zeroCross high forces lsEn low at once, and lsEn stays low for the rest of that switching cycle.
- R12: During and after reset the mode code is 01 (PFM), and the first switching cycle carries no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadWord | input | LOAD_BITS | Thermometer load code from the sensing converter |
| duty | input | PH_W | High-side on time in clocks |
| regBelow | input | 1 | Regulation comparator: output below target |
| limitOk | input | 1 | Current-limit comparator: 1 = below limit |
| zeroCross | input | 1 | Zero-current comparator: inductor current reached zero |
| sampleClk | output | 1 | Sampling strobe for the load converter |
| modeCode | output | 2 | Held mode code {PWM request, PFM request} |
| hsEn | output | 1 | High-side gate enable |
| lsEn | output | 1 | Low-side gate enable |

## Verification
Each switching cycle has a fixed phase, and the bench counts clocks from reset release to track that phase. The load word and the regulation comparator are taken at the final edge of a cycle and act from phase 0 of the following cycle. The bench therefore looks for the effect of a sample at phase 0 of the cycle after the strobe. It expects a regBelow value driven during cycle k to show up in cycle k+1, and a new duty value one cycle after it is set. The comparator gates act in the same clock, so those checks sample at the next falling edge after the stimulus. Skip patterns are predicted from a closed-form formula in the period position and the group count.

// File: rtl/pulser_pkg.sv
package pulser_pkg;

  typedef enum logic [1:0] {
    MODE_PWM = 2'd0,
    MODE_DSM = 2'd1,
    MODE_PFM = 2'd2
  } mode_e;

  // strobes from control to the gate datapath
  typedef struct packed {
    logic cycleEnd;
    logic pulseEn;
    logic pfmGate;
  } strobe_t;

  function automatic mode_e codeToMode(input logic [1:0] code);
    case (code)
      2'b00:   return MODE_DSM;
      2'b01:   return MODE_PFM;
      default: return MODE_PWM;   // 10, and 11 as fallback
    endcase
  endfunction

endpackage

// File: rtl/pulser_timebase.sv
module pulser_timebase #(
  parameter int CYCLE_LEN     = 8,
  parameter int SAMPLE_CYCLES = 16,
  localparam int PH_W = $clog2(CYCLE_LEN),
  localparam int SC_W = $clog2(SAMPLE_CYCLES)
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [PH_W-1:0] phase,
  output logic            cycleEnd,
  output logic            sampleNow
);

  logic [SC_W-1:0] cycCnt;

  assign cycleEnd  = (phase == PH_W'(CYCLE_LEN - 1));
  assign sampleNow = cycleEnd && (cycCnt == SC_W'(SAMPLE_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      cycCnt <= '0;
    end else if (cycleEnd) begin
      phase  <= '0;
      cycCnt <= sampleNow ? '0 : cycCnt + 1'b1;
    end else begin
      phase  <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/pulser_skipseq.sv
module pulser_skipseq #(
  parameter int NORM_CYCLES = 3,
  parameter int MAX_MODS    = 7,
  localparam int MOD_W = $clog2(MAX_MODS + 1),
  localparam int CNT_W = $clog2(((NORM_CYCLES > MAX_MODS) ? NORM_CYCLES : MAX_MODS) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleEnd,
  input  logic             restart,   // current cycle was not in skip mode
  input  logic             runDsm,    // next cycle is in skip mode
  input  logic [MOD_W-1:0] mods,
  output logic             skipNext
);

  logic             inMods, nIn;
  logic [CNT_W-1:0] cnt, nCnt, modsTop;
  logic [1:0]       slot, nSlot, rot, nRot;

  assign modsTop = CNT_W'(mods) - CNT_W'(1);

  always_comb begin
    nIn   = inMods;
    nCnt  = cnt;
    nSlot = slot;
    nRot  = rot;
    if (restart) begin
      nIn   = 1'b0;
      nCnt  = '0;
      nSlot = 2'd0;
      nRot  = 2'd0;
    end else if (!inMods) begin
      if (cnt >= CNT_W'(NORM_CYCLES - 1)) begin
        nIn   = 1'b1;
        nCnt  = '0;
        nSlot = 2'd0;
      end else begin
        nCnt = cnt + 1'b1;
      end
    end else if (slot == 2'd2) begin
      nSlot = 2'd0;
      nRot  = (rot == 2'd2) ? 2'd0 : rot + 2'd1;
      if (cnt >= modsTop) begin
        nIn  = 1'b0;
        nCnt = '0;
      end else begin
        nCnt = cnt + 1'b1;
      end
    end else begin
      nSlot = slot + 2'd1;
    end
  end

  assign skipNext = nIn && (nSlot == nRot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMods <= 1'b0;
      cnt    <= '0;
      slot   <= 2'd0;
      rot    <= 2'd0;
    end else if (cycleEnd) begin
      if (runDsm) begin
        inMods <= nIn;
        cnt    <= nCnt;
        slot   <= nSlot;
        rot    <= nRot;
      end else begin
        inMods <= 1'b0;
        cnt    <= '0;
        slot   <= 2'd0;
        rot    <= 2'd0;
      end
    end
  end

endmodule

// File: rtl/pulser_ctrl.sv
module pulser_ctrl
  import pulser_pkg::*;
#(
  parameter int LOAD_BITS     = 8,
  parameter int TAP_LO        = 1,
  parameter int TAP_MID       = 3,
  parameter int TAP_HI        = 6,
  parameter int CYCLE_LEN     = 8,
  parameter int SAMPLE_CYCLES = 16,
  parameter int NORM_CYCLES   = 3,
  parameter int MAX_MODS      = 7,
  localparam int PH_W   = $clog2(CYCLE_LEN),
  localparam int MOD_W  = $clog2(MAX_MODS + 1),
  localparam int ONES_W = $clog2(LOAD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LOAD_BITS-1:0] loadWord,
  input  logic                 regBelow,
  output logic [PH_W-1:0]      phase,
  output logic                 sampleClk,
  output logic [1:0]           modeCode,
  output strobe_t              strobes
);

  logic              cycleEnd, sampleNow, skipNext, pulseEnReg;
  logic [1:0]        codeReg, newCode, nextCode;
  logic [MOD_W-1:0]  modsReg, tableMods, nextMods;
  logic [ONES_W-1:0] onesCnt;
  int                gapV;
  mode_e             curMode, nextMode;

  pulser_timebase #(.CYCLE_LEN(CYCLE_LEN), .SAMPLE_CYCLES(SAMPLE_CYCLES)) uTime (
    .clk(clk), .rstN(rstN), .phase(phase), .cycleEnd(cycleEnd), .sampleNow(sampleNow)
  );

  // count of ones in the load word
  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < LOAD_BITS; i++)
      onesCnt = onesCnt + ONES_W'(loadWord[i]);
  end

  // fewer ones -> more skip groups per period
  always_comb begin
    gapV = LOAD_BITS - int'(onesCnt);
    if (gapV < 1)        gapV = 1;
    if (gapV > MAX_MODS) gapV = MAX_MODS;
    tableMods = MOD_W'(gapV);
  end

  assign newCode  = {loadWord[TAP_HI], ~(loadWord[TAP_MID] | loadWord[TAP_LO])};
  assign nextCode = sampleNow ? newCode : codeReg;
  assign nextMods = sampleNow ? tableMods : modsReg;
  assign curMode  = codeToMode(codeReg);
  assign nextMode = codeToMode(nextCode);

  pulser_skipseq #(.NORM_CYCLES(NORM_CYCLES), .MAX_MODS(MAX_MODS)) uSeq (
    .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd),
    .restart(curMode != MODE_DSM), .runDsm(nextMode == MODE_DSM),
    .mods(nextMods), .skipNext(skipNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg    <= 2'b01;
      modsReg    <= MOD_W'(1);
      pulseEnReg <= 1'b0;
    end else if (cycleEnd) begin
      codeReg <= nextCode;
      modsReg <= nextMods;
      case (nextMode)
        MODE_PFM: pulseEnReg <= regBelow;
        MODE_DSM: pulseEnReg <= ~skipNext;
        default:  pulseEnReg <= 1'b1;
      endcase
    end
  end

  assign sampleClk        = sampleNow;
  assign modeCode         = codeReg;
  assign strobes.cycleEnd = cycleEnd;
  assign strobes.pulseEn  = pulseEnReg;
  assign strobes.pfmGate  = (curMode == MODE_PFM);

endmodule

// File: rtl/pulser_gate.sv
module pulser_gate
  import pulser_pkg::*;
#(
  parameter int CYCLE_LEN = 8,
  localparam int PH_W     = $clog2(CYCLE_LEN),
  localparam int DUTY_MAX = CYCLE_LEN - 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PH_W-1:0] phase,
  input  strobe_t         strobes,
  input  logic [PH_W-1:0] duty,
  input  logic            limitOk,
  input  logic            zeroCross,
  output logic            hsEn,
  output logic            lsEn
);

  logic [PH_W-1:0] dutyReg, dutyC;
  logic            limTrip, zcSeen, hsWin, lsWin, limBlock;

  assign dutyC    = (dutyReg > PH_W'(DUTY_MAX)) ? PH_W'(DUTY_MAX) : dutyReg;
  assign hsWin    = strobes.pulseEn && (phase < dutyC);
  assign lsWin    = strobes.pulseEn && (dutyC != '0) && (phase > dutyC)
                    && (phase < PH_W'(CYCLE_LEN - 1));
  assign limBlock = strobes.pfmGate && (!limitOk || limTrip);
  assign hsEn     = hsWin && !limBlock;
  assign lsEn     = lsWin && !zeroCross && !zcSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyReg <= '0;
      limTrip <= 1'b0;
      zcSeen  <= 1'b0;
    end else if (strobes.cycleEnd) begin
      dutyReg <= duty;
      limTrip <= 1'b0;
      zcSeen  <= 1'b0;
    end else begin
      if (hsWin && strobes.pfmGate && !limitOk) limTrip <= 1'b1;
      if (zeroCross) zcSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/buck_mode_pulser.sv
module buck_mode_pulser
  import pulser_pkg::*;
#(
  parameter int LOAD_BITS     = 8,
  parameter int TAP_LO        = 1,
  parameter int TAP_MID       = 3,
  parameter int TAP_HI        = 6,
  parameter int CYCLE_LEN     = 8,
  parameter int SAMPLE_CYCLES = 16,
  parameter int NORM_CYCLES   = 3,
  parameter int MAX_MODS      = 7,
  localparam int PH_W = $clog2(CYCLE_LEN)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LOAD_BITS-1:0] loadWord,
  input  logic [PH_W-1:0]      duty,
  input  logic                 regBelow,
  input  logic                 limitOk,
  input  logic                 zeroCross,
  output logic                 sampleClk,
  output logic [1:0]           modeCode,
  output logic                 hsEn,
  output logic                 lsEn
);

  logic [PH_W-1:0] phase;
  strobe_t         strobes;

  pulser_ctrl #(
    .LOAD_BITS(LOAD_BITS), .TAP_LO(TAP_LO), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI),
    .CYCLE_LEN(CYCLE_LEN), .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .NORM_CYCLES(NORM_CYCLES), .MAX_MODS(MAX_MODS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .loadWord(loadWord), .regBelow(regBelow),
    .phase(phase), .sampleClk(sampleClk), .modeCode(modeCode), .strobes(strobes)
  );

  pulser_gate #(.CYCLE_LEN(CYCLE_LEN)) uGate (
    .clk(clk), .rstN(rstN), .phase(phase), .strobes(strobes), .duty(duty),
    .limitOk(limitOk), .zeroCross(zeroCross), .hsEn(hsEn), .lsEn(lsEn)
  );

endmodule

// File: rtl/pulser_checker.sv
module pulser_checker #(
  parameter int LOAD_BITS = 8,
  parameter int TAP_LO    = 1,
  parameter int TAP_MID   = 3,
  parameter int TAP_HI    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [LOAD_BITS-1:0] loadWord,
  input logic                 limitOk,
  input logic                 zeroCross,
  input logic                 sampleClk,
  input logic [1:0]           modeCode,
  input logic                 hsEn,
  input logic                 lsEn
);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEn && lsEn));

  p_dead_hs_ls_r4: assert property (@(posedge clk) disable iff (!rstN)
    hsEn |=> !lsEn);

  p_dead_ls_hs_r4: assert property (@(posedge clk) disable iff (!rstN)
    lsEn |=> !hsEn);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleClk |=> $stable(modeCode));

  p_code_decode_r1: assert property (@(posedge clk) disable iff (!rstN)
    sampleClk |=> modeCode == {$past(loadWord[TAP_HI]),
                               ~($past(loadWord[TAP_MID]) | $past(loadWord[TAP_LO]))});

  p_zero_cut_r11: assert property (@(posedge clk) disable iff (!rstN)
    zeroCross |-> !lsEn);

  p_limit_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'b01 && !limitOk) |-> !hsEn);

endmodule

bind buck_mode_pulser pulser_checker #(
  .LOAD_BITS(LOAD_BITS), .TAP_LO(TAP_LO), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI)
) uChk (
  .clk(clk), .rstN(rstN), .loadWord(loadWord), .limitOk(limitOk),
  .zeroCross(zeroCross), .sampleClk(sampleClk), .modeCode(modeCode),
  .hsEn(hsEn), .lsEn(lsEn)
);

// File: tb/sim_buck_mode_pulser.sv
`timescale 1ns/1ps
module sim_buck_mode_pulser;

  localparam int CL = 8;
  localparam int SC = 16;
  localparam int NC = 42;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] loadWord = 8'h00;
  logic [2:0] duty = 3'd3;
  logic       regBelow = 1'b0, limitOk = 1'b1, zeroCross = 1'b0;
  logic       sampleClk, hsEn, lsEn;
  logic [1:0] modeCode;

  int tick;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  // entries: load(8) code(2) kind(2: 0 PWM,1 skip,2 PFM) mods(4)
  localparam logic [15:0] VEC [0:9] = '{
    {8'hFF, 2'b10, 2'd0, 4'd0},
    {8'h3F, 2'b00, 2'd1, 4'd2},
    {8'h01, 2'b01, 2'd2, 4'd0},
    {8'h0F, 2'b00, 2'd1, 4'd4},
    {8'h41, 2'b11, 2'd0, 4'd0},
    {8'h03, 2'b00, 2'd1, 4'd6},
    {8'h7F, 2'b10, 2'd0, 4'd0},
    {8'h07, 2'b00, 2'd1, 4'd5},
    {8'h00, 2'b01, 2'd2, 4'd0},
    {8'h1F, 2'b00, 2'd1, 4'd3}
  };

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) begin
    if (!rstN) tick <= 0;
    else       tick <= tick + 1;
  end

  buck_mode_pulser u0 (
    .clk(clk), .rstN(rstN), .loadWord(loadWord), .duty(duty),
    .regBelow(regBelow), .limitOk(limitOk), .zeroCross(zeroCross),
    .sampleClk(sampleClk), .modeCode(modeCode), .hsEn(hsEn), .lsEn(lsEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gotoPhase(input int p);
    do @(negedge clk); while ((tick % CL) != p);
  endtask

  task automatic waitSample();
    do @(negedge clk); while (!sampleClk);
  endtask

  task automatic applyLoad(input logic [7:0] w);
    loadWord = w;
    waitSample();
    gotoPhase(0);
  endtask

  // skip pattern from R5..R7: k = cycles since entering the mode
  function automatic bit expPulse(input int kind, input int mods, input int k);
    int len, q, grp, slot;
    if (kind == 0) return 1'b1;
    if (kind == 2) return 1'b0;
    len  = 3 + 3 * mods;
    q    = k % len;
    if (q < 3) return 1'b1;
    grp  = (k / len) * mods + (q - 3) / 3;
    slot = (q - 3) % 3;
    return slot != (grp % 3);
  endfunction

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish();
    end
  end

  initial begin
    int mis, misLs, prevReg;
    // R12: reset state
    repeat (3) @(negedge clk);
    check(modeCode == 2'b01 && !hsEn && !lsEn && !sampleClk, "R12 reset outputs",
          {modeCode, hsEn, lsEn}, 4);
    rstN = 1'b1;
    mis = 0;
    for (int c = 0; c < 4; c++) begin
      gotoPhase(0);
      if (hsEn) mis++;
    end
    check(mis == 0, "R12 no pulse after reset", mis, 0);

    // R2: strobe timing
    waitSample();
    check((tick % (CL * SC)) == CL * SC - 1, "R2 strobe position", tick % (CL * SC), CL * SC - 1);

    // table walk (R1, R5, R6, R7, R10)
    regBelow = 1'b0;
    limitOk  = 1'b0;
    duty     = 3'd3;
    for (int v = 0; v < 10; v++) begin
      int kind, mods;
      kind = int'(VEC[v][5:4]);
      mods = int'(VEC[v][3:0]);
      applyLoad(8'hFF);
      applyLoad(VEC[v][15:8]);
      check(modeCode == VEC[v][7:6], "R1 mode code", modeCode, VEC[v][7:6]);
      mis = 0;
      misLs = 0;
      for (int k = 0; k < NC; k++) begin
        if (k != 0) gotoPhase(0);
        if (hsEn != expPulse(kind, mods, k)) mis++;
        gotoPhase(4);
        if (lsEn != expPulse(kind, mods, k)) misLs++;
      end
      check(mis == 0, "R6 R7 R5 R10 pulse pattern", mis, 0);
      check(misLs == 0, "R4 low side follows pulse", misLs, 0);
    end

    // R2: load changes between strobes are ignored
    applyLoad(8'hFF);
    loadWord = 8'h00;
    mis = 0;
    for (int c = 0; c < 6; c++) begin
      gotoPhase(0);
      if (!hsEn || modeCode != 2'b10) mis++;
    end
    check(mis == 0, "R2 held between strobes", mis, 0);
    waitSample();
    gotoPhase(0);
    check(modeCode == 2'b01, "R2 new code after strobe", modeCode, 1);

    // R8: PFM follows regulation comparator one cycle later
    limitOk = 1'b1;
    regBelow = 1'b0;
    applyLoad(8'h00);
    prevReg = 0;
    mis = 0;
    for (int k = 0; k < 12; k++) begin
      if (k != 0) gotoPhase(0);
      if (int'(hsEn) != prevReg) mis++;
      regBelow = ((k % 3) == 0);
      prevReg = int'(regBelow);
    end
    check(mis == 0, "R8 PFM pulse on demand", mis, 0);

    // R9: limit comparator in PFM
    regBelow = 1'b1;
    duty = 3'd5;
    gotoPhase(0);
    gotoPhase(1);
    check(hsEn == 1'b1, "R9 pulse before limit", hsEn, 1);
    limitOk = 1'b0;
    gotoPhase(2);
    check(hsEn == 1'b0, "R9 limit cuts pulse", hsEn, 0);
    limitOk = 1'b1;
    gotoPhase(3);
    check(hsEn == 1'b0, "R9 cut held in cycle", hsEn, 0);
    gotoPhase(0);
    check(hsEn == 1'b1, "R9 next cycle pulses", hsEn, 1);

    // R10: comparators ignored in PWM
    regBelow = 1'b0;
    limitOk = 1'b0;
    applyLoad(8'hFF);
    gotoPhase(0);
    check(hsEn == 1'b1, "R10 PWM ignores regBelow", hsEn, 1);
    gotoPhase(4);
    check(hsEn == 1'b1, "R10 PWM ignores limitOk", hsEn, 1);

    // R3 / R4 / R11 with duty 3
    duty = 3'd3;
    gotoPhase(0);
    gotoPhase(2);
    check(hsEn == 1'b1, "R3 last high phase", hsEn, 1);
    gotoPhase(3);
    check(!hsEn && !lsEn, "R4 dead time", {hsEn, lsEn}, 0);
    gotoPhase(4);
    check(lsEn == 1'b1, "R4 low side on", lsEn, 1);
    zeroCross = 1'b1;
    gotoPhase(5);
    check(lsEn == 1'b0, "R11 zero cross cut", lsEn, 0);
    zeroCross = 1'b0;
    gotoPhase(6);
    check(lsEn == 1'b0, "R11 cut held", lsEn, 0);
    gotoPhase(7);
    check(!hsEn && !lsEn, "R4 end dead time", {hsEn, lsEn}, 0);
    gotoPhase(4);
    check(lsEn == 1'b1, "R11 cleared next cycle", lsEn, 1);

    // R3: clamp and zero duty
    duty = 3'd7;
    gotoPhase(0);
    gotoPhase(5);
    check(hsEn == 1'b1, "R3 clamp phase 5 high", hsEn, 1);
    gotoPhase(6);
    check(!hsEn && !lsEn, "R3 clamp phase 6 low", {hsEn, lsEn}, 0);
    duty = 3'd0;
    gotoPhase(0);
    check(hsEn == 1'b0, "R3 duty zero no pulse", hsEn, 0);
    gotoPhase(4);
    check(lsEn == 1'b0, "R3 duty zero no low side", lsEn, 0);

    done = 1'b1;
    finish();
  end

endmodule